// File: doc/BRIEF.md
# DTMF Digit Serial Reporter

This block takes a DTMF key that upstream tone detection has already accepted and reports it on a single serial data line. The key arrives as a low-group row index and a high-group column index together with a one-cycle accept strobe. The block maps the key to a 4-bit code, appends a 4-bit checksum, and shifts out a start/stop framed 10-bit word at 1200 baud. An active-low valid line frames the transfer.

Bit timing comes from a fractional accumulator on the system clock (nominally 3.579545 MHz), so the average bit period is exact and no single bit deviates by more than one clock. A power-down input forces both outputs high, aborts any frame in flight and blocks new strobes. Tone detection, guard timing and pause handling belong to the surrounding logic.

Top module: `dtmf_serial_reporter`

## Requirements
- R1: Row index 0..3 selects 697/770/852/941 Hz and column index 0..3 selects 1209/1336/1477/1633 Hz. The keys are 1 2 3 A on row 0, 4 5 6 B on row 1, 7 8 9 C on row 2 and * 0 # D on row 3. Digits 1..9 map to their own value, 0 maps to 10, * to 11, # to 12, A to 13, B to 14, C to 15 and D to 0.
- R2: The checksum is the two's complement of the code modulo 16, so code 0 yields checksum 0.
- R3: The frame is sent LSB first as a start bit of 0, then code bits Q0..Q3, then checksum bits S0..S3, then a stop bit of 1.
- R4: Each bit lasts CLK_HZ/BAUD_HZ clocks on average, produced by a fractional accumulator. With CLK_HZ an exact multiple of BAUD_HZ, every bit is exactly that many clocks long.
- R5: The valid line goes low on the clock edge that samples an accept strobe in idle. The start bit begins exactly one bit time later.
- R6: The valid line returns high one bit time after the stop bit ends.
- R7: While the valid line is high, the data line is high.
- R8: An accept strobe that arrives while a report is in progress is ignored and does not change the frame or its timing.
- R9: While power-down is high, the data and valid lines are held high, a frame in flight is abandoned, and accept strobes are ignored.
- R10: After reset, both outputs are high and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down, active high |
| accept_i | input | 1 | One-cycle strobe: key is accepted |
| row_i | input | 2 | Low-group row index |
| col_i | input | 2 | High-group column index |
| dout_o | output | 1 | Serial data line, idles high |
| dv_n_o | output | 1 | Active-low report-valid line |

## Verification
The bench runs the block at 10 clocks per bit. All timing is counted from edge E0, the edge that samples the strobe. The valid line is checked low just after E0, and the start bit must not show before E10. Frame bit k is sampled in the middle of its window, five clocks after edge E(10+10k). The valid line must still be low after E119 and high after E120. All outputs are sampled on the falling clock edge, so every check lands between the two edges that bound the expected change. Power-down is checked immediately after it is raised, because its effect on the outputs is combinational.

// File: rtl/dtmf_rep_pkg.sv
package dtmf_rep_pkg;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned FRAME_BITS = 2 + 2 * CODE_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_TAIL
  } tx_state_e;

  function automatic code_t checksum(input code_t c);
    return code_t'(~c + 1'b1);
  endfunction
endpackage

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_rep_pkg::*;
(
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  output code_t      code_o
);
  always_comb begin
    unique case ({row_i, col_i})
      4'h0: code_o = 4'd1;
      4'h1: code_o = 4'd2;
      4'h2: code_o = 4'd3;
      4'h3: code_o = 4'd13;  // A
      4'h4: code_o = 4'd4;
      4'h5: code_o = 4'd5;
      4'h6: code_o = 4'd6;
      4'h7: code_o = 4'd14;  // B
      4'h8: code_o = 4'd7;
      4'h9: code_o = 4'd8;
      4'hA: code_o = 4'd9;
      4'hB: code_o = 4'd15;  // C
      4'hC: code_o = 4'd11;  // *
      4'hD: code_o = 4'd10;  // 0
      4'hE: code_o = 4'd12;  // #
      default: code_o = 4'd0;  // D
    endcase
  end
endmodule

// File: rtl/dtmf_baud_gen.sv
module dtmf_baud_gen #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned BAUD_HZ = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned ACC_W = $clog2(CLK_HZ + BAUD_HZ + 1);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(BAUD_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc_q, acc_sum;

  assign acc_sum = acc_q + STEP;
  assign tick_o  = !clr_i && (acc_sum >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (tick_o)  acc_q <= acc_sum - LIMIT;
    else              acc_q <= acc_sum;
  end
endmodule

// File: rtl/dtmf_frame_tx.sv
module dtmf_frame_tx
  import dtmf_rep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwr_down_i,
  input  logic  accept_i,
  input  code_t code_i,
  input  logic  tick_i,
  output logic  clr_o,
  output logic  dout_o,
  output logic  dv_n_o
);
  tx_state_e        state_q;
  code_t            code_q;
  logic [IDX_W-1:0] idx_q;
  logic [FRAME_BITS-1:0] frame;

  assign frame = {1'b1, checksum(code_q), code_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      idx_q   <= '0;
    end else if (pwr_down_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          state_q <= ST_LEAD;
          code_q  <= code_i;
          idx_q   <= '0;
        end
        ST_LEAD: if (tick_i) state_q <= ST_DATA;
        ST_DATA: if (tick_i) begin
          if (idx_q == IDX_W'(FRAME_BITS - 1)) state_q <= ST_TAIL;
          else                                 idx_q   <= idx_q + 1'b1;
        end
        default: if (tick_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o  = (state_q == ST_IDLE);
  assign dout_o = (state_q == ST_DATA) ? frame[idx_q] : 1'b1;
  assign dv_n_o = (state_q == ST_IDLE);
endmodule

// File: rtl/dtmf_serial_reporter.sv
module dtmf_serial_reporter
  import dtmf_rep_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned BAUD_HZ = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_down_i,
  input  logic       accept_i,
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  output logic       dout_o,
  output logic       dv_n_o
);
  code_t key_code;
  logic  baud_tick, baud_clr, tx_dout, tx_dv_n;

  dtmf_key_encoder u_enc (
    .row_i  (row_i),
    .col_i  (col_i),
    .code_o (key_code)
  );

  dtmf_baud_gen #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (baud_clr),
    .tick_o (baud_tick)
  );

  dtmf_frame_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .accept_i   (accept_i),
    .code_i     (key_code),
    .tick_i     (baud_tick),
    .clr_o      (baud_clr),
    .dout_o     (tx_dout),
    .dv_n_o     (tx_dv_n)
  );

  // power-down parks both lines high
  assign dout_o = tx_dout | pwr_down_i;
  assign dv_n_o = tx_dv_n | pwr_down_i;
endmodule

// File: rtl/dtmf_serial_reporter_chk.sv
module dtmf_serial_reporter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_down_i,
  input logic accept_i,
  input logic dout_o,
  input logic dv_n_o,
  input logic baud_tick
);
  a_r9_pd_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (dout_o && dv_n_o));

  a_r7_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_n_o |-> dout_o);

  a_r5_dv_falls_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && dv_n_o && !pwr_down_i) |=> (!dv_n_o || pwr_down_i));

  a_r8_dv_fall_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dv_n_o) |-> $past(accept_i));

  a_r4_dout_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dout_o) && !pwr_down_i && !$past(pwr_down_i)) |-> $past(baud_tick));

  a_r6_dv_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dv_n_o) && !pwr_down_i) |-> $past(baud_tick));
endmodule

bind dtmf_serial_reporter dtmf_serial_reporter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_down_i (pwr_down_i),
  .accept_i   (accept_i),
  .dout_o     (dout_o),
  .dv_n_o     (dv_n_o),
  .baud_tick  (baud_tick)
);

// File: tb/tb_dtmf_serial_reporter.sv
module tb_dtmf_serial_reporter;
  localparam int BIT = 10;

  logic clk = 1'b0, rst_n = 1'b0, pd = 1'b0, acc = 1'b0;
  logic [1:0] row = '0, col = '0;
  logic dout, dv_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dtmf_serial_reporter #(.CLK_HZ(12000), .BAUD_HZ(1200)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_down_i(pd), .accept_i(acc),
    .row_i(row), .col_i(col), .dout_o(dout), .dv_n_o(dv_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int r, input int c);
    if (c == 3) return (r == 3) ? 0 : 13 + r;
    if (r < 3)  return r * 3 + c + 1;
    return (c == 0) ? 11 : (c == 1) ? 10 : 12;
  endfunction

  function automatic int exp_bit(input int code, input int k);
    int s = (16 - code) % 16;
    if (k == 0) return 0;
    if (k <= 4) return (code >> (k - 1)) & 1;
    if (k <= 8) return (s >> (k - 5)) & 1;
    return 1;
  endfunction

  // strobe a key; timing counted from E0 (edge sampling the strobe)
  task automatic run_frame(input int r, input int c, input bit inject);
    int code = exp_code(r, c);
    @(negedge clk); row = 2'(r); col = 2'(c); acc = 1'b1;
    @(negedge clk); acc = 1'b0;
    chk(dv_n == 1'b0, "R5 dv low after E0", dv_n, 0);
    chk(dout == 1'b1, "R5 lead line high", dout, 1);
    for (int n = 1; n <= 130; n++) begin
      @(negedge clk);
      if (inject && n == 40) begin
        row = 2'(3 - r); col = 2'(3 - c); acc = 1'b1;
      end else acc = 1'b0;
      if (n == 9)  chk(dout == 1'b1, "R5 start not early", dout, 1);
      if (n == 10) chk(dout == 1'b0, "R4 start at E10", dout, 0);
      if (n >= 15 && n <= 105 && (n - 15) % BIT == 0)
        chk(int'(dout) == exp_bit(code, (n - 15) / BIT),
            (n - 15) / BIT inside {[1:4]} ? "R1 code bit" :
            (n - 15) / BIT inside {[5:8]} ? "R2 checksum bit" : "R3 frame bit",
            dout, exp_bit(code, (n - 15) / BIT));
      if (n == 119) chk(dv_n == 1'b0, "R6 dv still low", dv_n, 0);
      if (n == 120) chk(dv_n == 1'b1, "R6 dv high after tail", dv_n, 1);
      if (n == 125) chk(dout == 1'b1, "R7 idle line high", dout, 1);
      if (n == 130 && inject) chk(dv_n == 1'b1, "R8 no second report", dv_n, 1);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(dout == 1'b1, "R10 reset dout", dout, 1);
    chk(dv_n == 1'b1, "R10 reset dv_n", dv_n, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(dv_n == 1'b1 && dout == 1'b1, "R10 idle after reset", {dv_n, dout}, 3);
  endtask

  task automatic t_all_keys();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) run_frame(r, c, 1'b0);
  endtask

  task automatic t_ignore_accept();
    run_frame(1, 2, 1'b1);  // R8: strobe of key mirrored key at n=40
  endtask

  task automatic t_power_down();
    @(negedge clk); row = 2'd0; col = 2'd0; acc = 1'b1;
    @(negedge clk); acc = 1'b0;
    repeat (30) @(negedge clk);
    pd = 1'b1; #1;
    chk(dout == 1'b1 && dv_n == 1'b1, "R9 lines high at pd", {dv_n, dout}, 3);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      acc = (n == 5);
      if (n == 10) chk(dout == 1'b1 && dv_n == 1'b1, "R9 held high", {dv_n, dout}, 3);
    end
    acc = 1'b0; pd = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (n == 5 || n == 39)
        chk(dv_n == 1'b1 && dout == 1'b1, "R9 frame abandoned", {dv_n, dout}, 3);
    end
    run_frame(2, 3, 1'b0);  // recovery
  endtask

  initial begin
    t_reset();
    t_all_keys();
    t_ignore_accept();
    t_power_down();
    run_frame(3, 3, 1'b0);  // back-to-back D, zero checksum
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule